// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a synchronous static memory with two byte lanes and a built-in burst address generator, meant to serve as a small cache data store next to a processor. Every control input, the address and the write data are captured on the rising clock edge. A cycle is opened by one of two active-low address strobes. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write according to the write controls. While neither strobe is active, an advance input either steps the burst offset or holds it, and the write controls pick reading or writing at that address.

Reads are flow-through: no output register follows the array. The word at the registered address appears in the cycle right after the edge that sampled it. Writes are self-timed on the sampling edge, with one enable per byte lane and a global-write override. The data bus is presented in split form, with a read word and a drive enable that a pad ring turns into a tri-state bus. The drive enable is gated by an asynchronous, unsampled output enable. It is withheld on write cycles and after deselection.

The burst order is chosen by a static input: a linear order that wraps within the burst, or an order that XORs the step count into the starting offset.

Top module: `fts_burst_sram`

## Requirements
- R1: When `proc_strobe_n` is low and `cen1_n` is low, the cycle is a read that starts at `addr_i` if all chip enables are active, whatever `gwrite_n`, `wen_n` and `bsel_n` show; no array byte changes.
- R2: When `ctrl_strobe_n` is low and the processor strobe is not taken, with all chip enables active, a burst starts at `addr_i` and the cycle is a write if the R3/R4 decode selects any lane, otherwise a read.
- R3: `gwrite_n` low writes both lanes, regardless of `wen_n` and `bsel_n`.
- R4: With `gwrite_n` high and `wen_n` low, lane k (bits `[9k+8:9k]` of the data) is written when `bsel_n[k]` is low; both selects low write the whole word.
- R5: With `gwrite_n` and `wen_n` both high, the cycle is a read and no array byte changes.
- R6: With `order_il` low, the k-th address of a burst keeps the upper address bits and takes `(start[1:0] + k) mod 4` as its two low bits.
- R7: With `order_il` high, the k-th burst address takes `start[1:0] XOR k` as its two low bits.
- R8: With both strobes high on a selected device, `adv_n` low steps the burst offset and `adv_n` high holds it, and the write decode picks a read or a write at that address.
- R9: Read data is the array word at the address sampled on the previous edge, with no extra cycle of latency; a read just after a write at the same address returns the new data.
- R10: `oe_n` high forces `bus_drive_o` low at once, without waiting for a clock edge.
- R11: A strobe that is taken while any chip enable is inactive deselects the device: `bus_drive_o` is low from the next cycle and stays low through cycles with no strobe until a start with all enables active.
- R12: During a write cycle `bus_drive_o` is low, whatever `oe_n` shows.
- R13: With `cen1_n` high, a low `proc_strobe_n` is ignored: with `ctrl_strobe_n` high the burst keeps stepping as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr_i | input | 8 | External word address |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, always a read |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low, read or write |
| adv_n | input | 1 | Burst advance, active low |
| cen1_n | input | 1 | Chip enable, active low, also gates the processor strobe |
| cen2 | input | 1 | Chip enable, active high |
| cen3_n | input | 1 | Chip enable, active low |
| gwrite_n | input | 1 | Global write, active low, writes every lane |
| wen_n | input | 1 | Write enable for the lanes picked by bsel_n, active low |
| bsel_n | input | 2 | Per-lane byte select, active low |
| order_il | input | 1 | Static burst order: 0 linear, 1 XOR order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_data_i | input | 18 | Write data, sampled with the write command |
| rd_data_o | output | 18 | Flow-through read word at the registered address |
| bus_drive_o | output | 1 | Drive enable for the bidirectional data pads |

## Verification
Every address is first written with a global write and then read back through the processor strobe while every write control is asserted. This separates a working global write from one that drops a lane. It also shows that the processor strobe never writes. Bursts run from all four start offsets in both orders and wrap past the fourth beat, so an adder can be told apart from an XOR. Lane writes use each single select, both selects, and the override with the selects high, which shows which lane each select drives. Suspend, deselect with each enable, the ignored processor strobe and the output enable toggled between edges each check one control path against the bench's own array model.

// File: rtl/fts_pkg.sv
package fts_pkg;

    // Command decoded from the strobes for one clock edge.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,   // no strobe, device idle: stay deselected
        CMD_DESEL = 2'd1,   // strobe taken with an enable inactive
        CMD_START = 2'd2,   // strobe taken, load external address
        CMD_STEP  = 2'd3    // no strobe, device selected: continue/suspend
    } cmd_e;

endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
    import fts_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                 proc_strobe_n,
    input  logic                 ctrl_strobe_n,
    input  logic                 adv_n,
    input  logic                 cen1_n,
    input  logic                 cen2,
    input  logic                 cen3_n,
    input  logic                 gwrite_n,
    input  logic                 wen_n,
    input  logic [NUM_BYTES-1:0] bsel_n,
    input  logic                 selected,
    output cmd_e                 cmd,
    output logic [NUM_BYTES-1:0] lane_we,
    output logic                 advance
);

    logic                 all_enabled;
    logic                 proc_take;
    logic                 ctrl_take;
    logic [NUM_BYTES-1:0] lane_req;

    always_comb begin
        all_enabled = !cen1_n && cen2 && !cen3_n;
        // The processor strobe is blocked while cen1_n is high.
        proc_take   = !proc_strobe_n && !cen1_n;
        ctrl_take   = !ctrl_strobe_n && !proc_take;

        if (!gwrite_n) begin
            lane_req = '1;
        end else if (!wen_n) begin
            lane_req = ~bsel_n;
        end else begin
            lane_req = '0;
        end

        cmd     = CMD_HOLD;
        lane_we = '0;
        advance = 1'b0;

        if (proc_take) begin
            cmd = all_enabled ? CMD_START : CMD_DESEL;
        end else if (ctrl_take) begin
            cmd = all_enabled ? CMD_START : CMD_DESEL;
            if (all_enabled) begin
                lane_we = lane_req;
            end
        end else if (selected) begin
            cmd     = CMD_STEP;
            lane_we = lane_req;
            advance = !adv_n;
        end
    end

endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_off,
    input  logic [BURST_W-1:0] step_cnt,
    input  logic               order_il,
    output logic [BURST_W-1:0] offset
);

    logic [BURST_W-1:0] lin_off;
    logic [BURST_W-1:0] xor_off;

    always_comb begin
        lin_off = start_off + step_cnt;
        xor_off = start_off ^ step_cnt;
        offset  = order_il ? xor_off : lin_off;
    end

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2
) (
    input  logic                          clk,
    input  logic [NUM_BYTES-1:0]          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [BYTE_W*NUM_BYTES-1:0]   wdata,
    input  logic [ADDR_W-1:0]             raddr,
    output logic [BYTE_W*NUM_BYTES-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        logic [BYTE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we[k]) begin
                store[waddr] <= wdata[k*BYTE_W +: BYTE_W];
            end
        end

        // Flow-through: no output register.
        assign rdata[k*BYTE_W +: BYTE_W] = store[raddr];
    end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2,
    parameter int BURST_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          proc_strobe_n,
    input  logic                          ctrl_strobe_n,
    input  logic                          adv_n,
    input  logic                          cen1_n,
    input  logic                          cen2,
    input  logic                          cen3_n,
    input  logic                          gwrite_n,
    input  logic                          wen_n,
    input  logic [NUM_BYTES-1:0]          bsel_n,
    input  logic                          order_il,
    input  logic                          oe_n,
    input  logic [BYTE_W*NUM_BYTES-1:0]   wr_data_i,
    output logic [BYTE_W*NUM_BYTES-1:0]   rd_data_o,
    output logic                          bus_drive_o
);

    localparam int DATA_W  = BYTE_W * NUM_BYTES;
    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic               sel;
        logic               wr;
        logic [UPPER_W-1:0] upper;
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } state_t;

    state_t               st_d;
    state_t               st_q;
    cmd_e                 cmd;
    logic [NUM_BYTES-1:0] lane_we;
    logic                 advance;
    logic [BURST_W-1:0]   off_d;
    logic [BURST_W-1:0]   off_q;
    logic [ADDR_W-1:0]    waddr;
    logic [ADDR_W-1:0]    raddr;
    logic [DATA_W-1:0]    array_rd;

    fts_cmd_decode #(
        .NUM_BYTES (NUM_BYTES)
    ) i_decode (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .cen1_n        (cen1_n),
        .cen2          (cen2),
        .cen3_n        (cen3_n),
        .gwrite_n      (gwrite_n),
        .wen_n         (wen_n),
        .bsel_n        (bsel_n),
        .selected      (st_q.sel),
        .cmd           (cmd),
        .lane_we       (lane_we),
        .advance       (advance)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_START: begin
                st_d.sel   = 1'b1;
                st_d.wr    = |lane_we;
                st_d.upper = addr_i[ADDR_W-1:BURST_W];
                st_d.base  = addr_i[BURST_W-1:0];
                st_d.cnt   = '0;
            end
            CMD_STEP: begin
                st_d.wr  = |lane_we;
                st_d.cnt = st_q.cnt + {{(BURST_W-1){1'b0}}, advance};
            end
            default: begin
                st_d.sel = 1'b0;
                st_d.wr  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fts_burst_seq #(
        .BURST_W (BURST_W)
    ) i_seq_next (
        .start_off (st_d.base),
        .step_cnt  (st_d.cnt),
        .order_il  (order_il),
        .offset    (off_d)
    );

    fts_burst_seq #(
        .BURST_W (BURST_W)
    ) i_seq_cur (
        .start_off (st_q.base),
        .step_cnt  (st_q.cnt),
        .order_il  (order_il),
        .offset    (off_q)
    );

    assign waddr = {st_d.upper, off_d};
    assign raddr = {st_q.upper, off_q};

    fts_lane_array #(
        .ADDR_W    (ADDR_W),
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) i_array (
        .clk   (clk),
        .we    (lane_we),
        .waddr (waddr),
        .wdata (wr_data_i),
        .raddr (raddr),
        .rdata (array_rd)
    );

    assign rd_data_o   = array_rd;
    assign bus_drive_o = st_q.sel && !st_q.wr && !oe_n;

endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              adv_n,
    input logic              cen1_n,
    input logic              cen2,
    input logic              cen3_n,
    input logic              gwrite_n,
    input logic              wen_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              bus_drive_o
);

    logic en_all;
    logic p_take;
    logic c_take;

    assign en_all = !cen1_n && cen2 && !cen3_n;
    assign p_take = !proc_strobe_n && !cen1_n;
    assign c_take = !ctrl_strobe_n && !p_take;

    a_r10_oe_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_drive_o);

    a_r11_desel_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && !en_all) |=> !bus_drive_o);

    a_r11_desel_proc: assert property (@(posedge clk) disable iff (!rst_n)
        (p_take && !en_all) |=> !bus_drive_o);

    a_r12_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && en_all && !gwrite_n) |=> !bus_drive_o);

    a_r1_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (p_take && en_all) |=> (oe_n || bus_drive_o));

    a_r8_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && adv_n && gwrite_n && wen_n && bus_drive_o)
        |=> $stable(rd_data_o));

endmodule

bind fts_burst_sram fts_burst_sram_chk #(
    .DATA_W (BYTE_W * NUM_BYTES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .cen1_n        (cen1_n),
    .cen2          (cen2),
    .cen3_n        (cen3_n),
    .gwrite_n      (gwrite_n),
    .wen_n         (wen_n),
    .oe_n          (oe_n),
    .rd_data_o     (rd_data_o),
    .bus_drive_o   (bus_drive_o)
);

// File: tb/test_fts_burst_sram.sv
module test_fts_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          cen1_n = 1'b0;
    logic          cen2 = 1'b1;
    logic          cen3_n = 1'b0;
    logic          gwrite_n = 1'b1;
    logic          wen_n = 1'b1;
    logic [1:0]    bsel_n = 2'b11;
    logic          order_il = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          bus_drive_o;

    logic [DW-1:0] ref_mem [DEPTH];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fts_burst_sram i_fts_burst_sram (
        .clk (clk), .rst_n (rst_n), .addr_i (addr_i),
        .proc_strobe_n (proc_strobe_n), .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n (adv_n), .cen1_n (cen1_n), .cen2 (cen2), .cen3_n (cen3_n),
        .gwrite_n (gwrite_n), .wen_n (wen_n), .bsel_n (bsel_n),
        .order_il (order_il), .oe_n (oe_n), .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o), .bus_drive_o (bus_drive_o)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 1237 + salt * 7919 + 341) & 32'h3FFFF);
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] s, input int k, input logic il);
        logic [1:0] kk;
        kk = 2'(k);
        return il ? {s[AW-1:2], s[1:0] ^ kk} : {s[AW-1:2], s[1:0] + kk};
    endfunction

    // Lane mask from the write decode stated in R3/R4/R5.
    function automatic logic [1:0] lane_mask(input logic gw, input logic we, input logic [1:0] bs);
        if (!gw) return 2'b11;
        if (!we) return ~bs;
        return 2'b00;
    endfunction

    function automatic void ref_write(input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d);
        if (m[0]) ref_mem[a][8:0]  = d[8:0];
        if (m[1]) ref_mem[a][17:9] = d[17:9];
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        gwrite_n = 1'b1; wen_n = 1'b1; bsel_n = 2'b11;
        cen1_n = 1'b0; cen2 = 1'b1; cen3_n = 1'b0;
    endtask

    task automatic expect_read(input logic [AW-1:0] a, input string req);
        check(bus_drive_o == 1'b1, req, DW'(bus_drive_o), DW'(1));
        check(rd_data_o == ref_mem[a], req, rd_data_o, ref_mem[a]);
    endtask

    task automatic expect_hiz(input string req);
        check(bus_drive_o == 1'b0, req, DW'(bus_drive_o), DW'(0));
    endtask

    task automatic ctrl_start(input logic [AW-1:0] a, input logic gw, input logic we,
                              input logic [1:0] bs, input logic [DW-1:0] d);
        addr_i = a; ctrl_strobe_n = 1'b0; gwrite_n = gw; wen_n = we; bsel_n = bs; wr_data_i = d;
        ref_write(a, lane_mask(gw, we, bs), d);
        tick();
    endtask

    task automatic proc_start(input logic [AW-1:0] a);
        addr_i = a; proc_strobe_n = 1'b0;
        // R1: write controls asserted but must be ignored
        gwrite_n = 1'b0; wen_n = 1'b0; bsel_n = 2'b00; wr_data_i = ~ref_mem[a];
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        expect_hiz("R11 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        expect_hiz("R11 idle after reset");

        // R3: global write fills every word, selects held high
        for (int a = 0; a < DEPTH; a++) begin
            ctrl_start(AW'(a), 1'b0, 1'b1, 2'b11, pat(a, 0));
            if (a < 4) expect_hiz("R12 write cycle no drive");
        end
        // R1 R9 R3: processor reads of every word, write inputs asserted
        for (int a = 0; a < DEPTH; a++) begin
            proc_start(AW'(a));
            expect_read(AW'(a), "R1 R3 R9 proc read sweep");
        end

        // R6 R7: bursts from every offset in both orders, wrapping
        for (int il = 0; il < 2; il++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] st;
                st = AW'(8'h40 + s + il * 16);
                order_il = il[0];
                proc_start(st);
                expect_read(burst_addr(st, 0, il[0]), il != 0 ? "R7 burst beat0" : "R6 burst beat0");
                for (int k = 1; k < 6; k++) begin
                    adv_n = 1'b0;
                    tick();
                    expect_read(burst_addr(st, k, il[0]), il != 0 ? "R7 burst step" : "R6 burst step");
                end
            end
        end
        order_il = 1'b0;

        // R4: lane writes
        ctrl_start(8'h10, 1'b1, 1'b0, 2'b10, pat(16, 5));
        ctrl_start(8'h11, 1'b1, 1'b0, 2'b01, pat(17, 5));
        ctrl_start(8'h12, 1'b1, 1'b0, 2'b00, pat(18, 5));
        // R3: override with selects high and write enable high
        ctrl_start(8'h13, 1'b0, 1'b1, 2'b11, pat(19, 5));
        for (int a = 16; a < 20; a++) begin
            proc_start(AW'(a));
            expect_read(AW'(a), "R4 R3 lane write readback");
        end

        // R5 R2: controller strobe with no write decode reads
        ctrl_start(8'h14, 1'b1, 1'b1, 2'b00, pat(20, 9));
        expect_read(8'h14, "R5 R2 ctrl read no change");

        // R8: burst write with continue and suspend
        ctrl_start(8'h21, 1'b0, 1'b1, 2'b11, pat(33, 1));
        adv_n = 1'b0; gwrite_n = 1'b0; wr_data_i = pat(34, 1); ref_write(8'h22, 2'b11, pat(34, 1)); tick();
        adv_n = 1'b1; gwrite_n = 1'b0; wr_data_i = pat(35, 1); ref_write(8'h22, 2'b11, pat(35, 1)); tick();
        expect_hiz("R12 burst write no drive");
        adv_n = 1'b0; tick();
        expect_read(8'h23, "R8 continue read after write");
        adv_n = 1'b1; tick();
        expect_read(8'h23, "R8 suspend read holds");
        adv_n = 1'b0; tick();
        expect_read(8'h20, "R8 continue wraps");
        for (int a = 32; a < 36; a++) begin
            proc_start(AW'(a));
            expect_read(AW'(a), "R8 burst write readback");
        end

        // R9: read right after write at the same address
        ctrl_start(8'h50, 1'b0, 1'b1, 2'b11, pat(80, 3));
        wen_n = 1'b1; gwrite_n = 1'b1; tick();
        expect_read(8'h50, "R9 read after write");

        // R10: output enable acts between edges
        proc_start(8'h51);
        expect_read(8'h51, "R10 driven before oe");
        oe_n = 1'b1; #1;
        expect_hiz("R10 oe high async");
        oe_n = 1'b0; #1;
        expect_read(8'h51, "R10 oe low again");

        // R11: deselect via each enable
        addr_i = 8'h60; ctrl_strobe_n = 1'b0; cen2 = 1'b0; tick();
        expect_hiz("R11 deselect cen2");
        tick();
        expect_hiz("R11 stays deselected");
        addr_i = 8'h60; proc_strobe_n = 1'b0; cen3_n = 1'b1; tick();
        expect_hiz("R11 deselect cen3");
        addr_i = 8'h61; ctrl_strobe_n = 1'b0; cen1_n = 1'b1; tick();
        expect_hiz("R11 deselect cen1");
        proc_start(8'h61);
        expect_read(8'h61, "R11 reselect");

        // R13: blocked processor strobe continues the burst
        proc_start(8'h70);
        adv_n = 1'b0; tick();
        expect_read(8'h71, "R13 before ignore");
        proc_strobe_n = 1'b0; cen1_n = 1'b1; adv_n = 1'b0; addr_i = 8'h90; tick();
        expect_read(8'h72, "R13 ignored proc strobe");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule